// File: doc/BRIEF.md
# Linear Sensor Line Statistics Engine

This block sits behind the digitiser of a linear image sensor. It receives one sample per pixel slot, each tagged with a region code by the readout sequencer. For every line it produces two values. The first is the black reference: the average over the shielded black slots only. The second is a set of uniformity figures over the active array: the mean, the largest and smallest sample, and the signed distance of each extreme from the mean. Lead-in slots whose level is still settling, and the guard slots at both ends of the active array, are excluded from every figure. A system can use the results to characterise dark frames. It can also use them for black-level removal. Software turns the extremes and the mean into percentage non-uniformity.

Samples arrive on a valid/ready stream. The sample that carries `in_last` closes the line. After that sample the block computes both means with one shared sequential restoring divider. While it does so, `in_ready` is low, and this is the only back-pressure the block applies on its own. A second, optional stream passes each active sample onward with the black reference of the previously published line removed, clamped at zero. An active sample is taken only when the downstream side is ready, so `in_ready` follows `out_ready` for active slots. Non-active slots are taken regardless of `out_ready`. The results are published together with a one-cycle `done` pulse and then held until the next pulse.

Top module: `ccd_line_stats`

## Requirements
- R1: Region codes are 0 for settling lead-in, 1 for shielded black, 2 for active and 3 for guard. Only code 1 feeds the black sum and only code 2 feeds the active figures; codes 0 and 3 change no result.
- R2: `ob_mean` is the floor of the sum of the black samples of the line divided by N_OB.
- R3: `act_mean` is the floor of the sum of the active samples divided by N_ACT. The accumulator is DW+clog2(N_ACT+1) bits wide (AW), so N_ACT full-scale samples cannot overflow it.
- R4: `act_max` and `act_min` are the largest and smallest active samples of the line.
- R5: `dev_hi` = act_max − act_mean and `dev_lo` = act_min − act_mean, as DW+1-bit two's-complement values.
- R6: `cnt_err` is published high when the line held a number of active samples other than N_ACT. All other results are still published.
- R7: `done` is high for exactly one cycle, 2·AW+5 clock edges after the edge that accepts the `in_last` sample. All results change in that same cycle and then hold until the next `done`.
- R8: `in_ready` is low from the edge that accepts the `in_last` sample until the `done` cycle. It is high again in the `done` cycle.
- R9: `out_valid` is `in_valid` while the block is accepting and the region is active. `out_data` is the sample minus the last published `ob_mean` (zero after reset), clamped at zero.
- R10: An active sample is accepted only in a cycle with `out_ready` high. Samples of other regions are accepted whatever `out_ready` is.
- R11: After reset all result outputs, `cnt_err` and `done` are zero, and `in_ready` is high for a non-active region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high with in_valid |
| in_region | input | 2 | Region code of the sample |
| in_data | input | DW | Digitised sample |
| in_last | input | 1 | Sample closes the line |
| out_valid | output | 1 | Black-corrected active sample valid |
| out_ready | input | 1 | Downstream ready for corrected sample |
| out_data | output | DW | Active sample minus previous black mean, floored at zero |
| done | output | 1 | One-cycle pulse, results updated |
| ob_mean | output | DW | Black reference mean |
| act_mean | output | DW | Active mean |
| act_max | output | DW | Active maximum |
| act_min | output | DW | Active minimum |
| dev_hi | output | DW+1 | Signed max − mean |
| dev_lo | output | DW+1 | Signed min − mean |
| cnt_err | output | 1 | Active sample count differed from N_ACT |

## Verification
The bench builds the block with DW=8, N_OB=3 and N_ACT=10. With these values the accumulator and divider are 12 bits wide and a full line closes in about 60 cycles. Many lines then fit in a short run: ramps, constants, scrambled values, alternating full-scale extremes, and lines one sample short and one sample long for the count error. Hot values in the lead-in and guard slots prove they are excluded. Toggling `out_ready` exercises back-pressure on active slots only, and the corrected stream is checked against the mean published by the previous line.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
  typedef enum logic [1:0] {
    REG_LEADIN = 2'd0,
    REG_BLACK  = 2'd1,
    REG_ACTIVE = 2'd2,
    REG_GUARD  = 2'd3
  } region_t;

  typedef enum logic [2:0] {
    S_ACC, S_OBGO, S_OBW, S_ACGO, S_ACW, S_PUB
  } phase_t;
endpackage

// File: rtl/lsp_div.sv
module lsp_div #(
  parameter int NW  = 24,
  parameter int DVW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [NW-1:0]  dividend,
  input  logic [DVW-1:0] divisor,
  output logic [NW-1:0]  quot,
  output logic           fin
);
  localparam int CNTW = $clog2(NW + 1);

  logic [DVW-1:0]  rem;
  logic [DVW-1:0]  div_r;
  logic [NW-1:0]   q;
  logic [CNTW-1:0] cnt;
  logic [DVW:0]    shifted;
  logic            fits;

  assign shifted = {rem, q[NW-1]};
  assign fits    = shifted >= {1'b0, div_r};
  assign quot    = q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem   <= '0;
      div_r <= '0;
      q     <= '0;
      cnt   <= '0;
      fin   <= 1'b0;
    end else if (start) begin
      rem   <= '0;
      div_r <= divisor;
      q     <= dividend;
      cnt   <= CNTW'(NW);
      fin   <= 1'b0;
    end else if (cnt != '0) begin
      rem <= fits ? DVW'(shifted - {1'b0, div_r}) : shifted[DVW-1:0];
      q   <= {q[NW-2:0], fits};
      cnt <= cnt - 1'b1;
      fin <= (cnt == CNTW'(1));
    end else begin
      fin <= 1'b0;
    end
  end

  // R2 / R3: a finished quotient leaves a remainder below the divisor
  a_r2_rem_lt_div: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (rem < div_r));
endmodule

// File: rtl/lsp_accum.sv
module lsp_accum
  import lsp_pkg::*;
#(
  parameter int DW    = 12,
  parameter int N_ACT = 2088,
  parameter int AW    = 24,
  parameter int CW    = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          take,
  input  region_t       region,
  input  logic [DW-1:0] data,
  output logic [AW-1:0] ob_sum,
  output logic [AW-1:0] act_sum,
  output logic [DW-1:0] act_max,
  output logic [DW-1:0] act_min,
  output logic [CW-1:0] act_cnt
);
  localparam logic [CW-1:0] CNT_TOP = '1;

  logic [AW:0] act_wide;
  assign act_wide = {1'b0, act_sum} + (AW+1)'(data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ob_sum  <= '0;
      act_sum <= '0;
      act_max <= '0;
      act_min <= '1;
      act_cnt <= '0;
    end else if (clr) begin
      ob_sum  <= '0;
      act_sum <= '0;
      act_max <= '0;
      act_min <= '1;
      act_cnt <= '0;
    end else if (take) begin
      case (region)
        REG_BLACK:  ob_sum <= ob_sum + AW'(data);
        REG_ACTIVE: begin
          act_sum <= act_wide[AW-1:0];
          if (data > act_max) act_max <= data;
          if (data < act_min) act_min <= data;
          if (act_cnt != CNT_TOP) act_cnt <= act_cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R3: within a nominal line the active sum never carries out
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (take && region == REG_ACTIVE && act_cnt < CW'(N_ACT)) |-> !act_wide[AW]);

  // R4: once an active sample is seen, the extremes are ordered
  a_r4_min_le_max: assert property (@(posedge clk) disable iff (!rst_n)
    (act_cnt != '0) |-> (act_min <= act_max));
endmodule

// File: rtl/ccd_line_stats.sv
module ccd_line_stats
  import lsp_pkg::*;
#(
  parameter int DW      = 12,
  parameter int N_OB    = 18,
  parameter int N_ACT   = 2088,
  parameter bit CORR_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_region,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          done,
  output logic [DW-1:0] ob_mean,
  output logic [DW-1:0] act_mean,
  output logic [DW-1:0] act_max,
  output logic [DW-1:0] act_min,
  output logic [DW:0]   dev_hi,
  output logic [DW:0]   dev_lo,
  output logic          cnt_err
);
  localparam int CNTB = $clog2(N_ACT + 1);
  localparam int AW   = DW + CNTB;
  localparam int CW   = CNTB + 1;
  localparam int DMAX = (N_OB > N_ACT) ? N_OB : N_ACT;
  localparam int DVW  = $clog2(DMAX + 1);

  region_t region;
  phase_t  state;
  logic    accepting, take;
  logic    dv_start, dv_fin;
  logic [AW-1:0]  dv_dividend, dv_quot;
  logic [DVW-1:0] dv_divisor;
  logic [AW-1:0]  ob_sum, act_sum;
  logic [DW-1:0]  cur_max, cur_min;
  logic [CW-1:0]  act_cnt;
  logic [DW-1:0]  ob_q_r, act_q_r;

  assign region    = region_t'(in_region);
  assign accepting = (state == S_ACC);
  assign take      = in_valid && in_ready;

  generate
    if (CORR_EN) begin : g_corr
      assign in_ready  = accepting && (region != REG_ACTIVE || out_ready);
      assign out_valid = in_valid && accepting && (region == REG_ACTIVE);
      assign out_data  = (in_data > ob_mean) ? (in_data - ob_mean) : '0;

      // R9: the corrected sample never exceeds the raw one
      a_r9_corr_sat: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data <= in_data));
      // R10: a stalled corrected sample holds the input stream
      a_r10_hold_in: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
    end else begin : g_nocorr
      assign in_ready  = accepting;
      assign out_valid = 1'b0;
      assign out_data  = '0;
    end
  endgenerate

  lsp_accum #(.DW(DW), .N_ACT(N_ACT), .AW(AW), .CW(CW)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (state == S_PUB),
    .take    (take),
    .region  (region),
    .data    (in_data),
    .ob_sum  (ob_sum),
    .act_sum (act_sum),
    .act_max (cur_max),
    .act_min (cur_min),
    .act_cnt (act_cnt)
  );

  assign dv_start    = (state == S_OBGO) || (state == S_ACGO);
  assign dv_dividend = (state == S_OBGO) ? ob_sum : act_sum;
  assign dv_divisor  = (state == S_OBGO) ? DVW'(N_OB) : DVW'(N_ACT);

  lsp_div #(.NW(AW), .DVW(DVW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (dv_start),
    .dividend (dv_dividend),
    .divisor  (dv_divisor),
    .quot     (dv_quot),
    .fin      (dv_fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_ACC;
      ob_q_r  <= '0;
      act_q_r <= '0;
    end else begin
      case (state)
        S_ACC:  if (take && in_last) state <= S_OBGO;
        S_OBGO: state <= S_OBW;
        S_OBW:  if (dv_fin) begin
                  ob_q_r <= dv_quot[DW-1:0];
                  state  <= S_ACGO;
                end
        S_ACGO: state <= S_ACW;
        S_ACW:  if (dv_fin) begin
                  act_q_r <= dv_quot[DW-1:0];
                  state   <= S_PUB;
                end
        S_PUB:  state <= S_ACC;
        default: state <= S_ACC;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      ob_mean  <= '0;
      act_mean <= '0;
      act_max  <= '0;
      act_min  <= '0;
      dev_hi   <= '0;
      dev_lo   <= '0;
      cnt_err  <= 1'b0;
    end else begin
      done <= (state == S_PUB);
      if (state == S_PUB) begin
        ob_mean  <= ob_q_r;
        act_mean <= act_q_r;
        act_max  <= cur_max;
        act_min  <= cur_min;
        dev_hi   <= {1'b0, cur_max} - {1'b0, act_q_r};
        dev_lo   <= {1'b0, cur_min} - {1'b0, act_q_r};
        cnt_err  <= (act_cnt != CW'(N_ACT));
      end
    end
  end

  // R7: the completion strobe lasts a single cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: results stay put between strobes
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(act_mean) && $stable(ob_mean)));
  // R8: no input is taken while the line is being resolved
  a_r8_busy_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !accepting |-> !in_ready);
endmodule

// File: tb/sim_ccd_line_stats.sv
module sim_ccd_line_stats;
  localparam int DW    = 8;
  localparam int N_OB  = 3;
  localparam int N_ACT = 10;
  localparam int AW    = DW + $clog2(N_ACT + 1);
  localparam int LAT   = 2 * AW + 5;
  localparam int FULL  = (1 << DW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [1:0]    in_region = 2'd0;
  logic [DW-1:0] in_data = '0;
  logic          in_last = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [DW-1:0] out_data;
  logic          done;
  logic [DW-1:0] ob_mean, act_mean, act_max, act_min;
  logic [DW:0]   dev_hi, dev_lo;
  logic          cnt_err;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  int lfsr = 32'h1d3;

  always #5 clk = ~clk;

  ccd_line_stats #(.DW(DW), .N_OB(N_OB), .N_ACT(N_ACT), .CORR_EN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_region(in_region), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .done(done), .ob_mean(ob_mean), .act_mean(act_mean), .act_max(act_max),
    .act_min(act_min), .dev_hi(dev_hi), .dev_lo(dev_lo), .cnt_err(cnt_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model, evaluated at every falling edge
  int  m_busy, m_ob_sum, m_ac_sum, m_ac_cnt, m_ac_max, m_ac_min;
  int  s_ob, s_am, s_mx, s_mn, s_err;
  int  e_ob, e_am, e_mx, e_mn, e_hi, e_lo, e_err;
  bit  e_done, p_fire, p_last;
  int  p_reg, p_dat;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_busy = 0; p_fire = 0; e_done = 0;
      m_ob_sum = 0; m_ac_sum = 0; m_ac_cnt = 0; m_ac_max = 0; m_ac_min = FULL;
      e_ob = 0; e_am = 0; e_mx = 0; e_mn = 0; e_hi = 0; e_lo = 0; e_err = 0;
    end else if (!finished) begin
      e_done = 0;
      if (p_fire) begin
        if (p_reg == 1) m_ob_sum += p_dat;
        if (p_reg == 2) begin
          m_ac_sum += p_dat; m_ac_cnt++;
          if (p_dat > m_ac_max) m_ac_max = p_dat;
          if (p_dat < m_ac_min) m_ac_min = p_dat;
        end
        if (p_last) begin
          s_ob = m_ob_sum / N_OB; s_am = m_ac_sum / N_ACT;
          s_mx = m_ac_max; s_mn = m_ac_min; s_err = (m_ac_cnt != N_ACT);
          m_ob_sum = 0; m_ac_sum = 0; m_ac_cnt = 0; m_ac_max = 0; m_ac_min = FULL;
          m_busy = LAT;
        end
      end else if (m_busy > 0) begin
        m_busy--;
        if (m_busy == 0) begin
          e_done = 1; e_ob = s_ob; e_am = s_am; e_mx = s_mx; e_mn = s_mn;
          e_hi = s_mx - s_am; e_lo = s_mn - s_am; e_err = s_err;
        end
      end
      begin
        bit rdy, ov;
        rdy = (m_busy == 0) && (in_region != 2'd2 || out_ready);
        ov  = in_valid && (m_busy == 0) && in_region == 2'd2;
        if (m_busy == 0 && in_region == 2'd2 && !out_ready)
          chk("R10", "in_ready stalled", int'(in_ready), 0);
        else
          chk("R8", "in_ready", int'(in_ready), int'(rdy));
        chk("R7", "done", int'(done), int'(e_done));
        chk("R9", "out_valid", int'(out_valid), int'(ov));
        if (ov) chk("R9", "out_data", int'(out_data),
                    (int'(in_data) > e_ob) ? int'(in_data) - e_ob : 0);
        chk("R1 R2", "ob_mean", int'(ob_mean), e_ob);
        chk("R3", "act_mean", int'(act_mean), e_am);
        chk("R4", "act_max", int'(act_max), e_mx);
        chk("R4", "act_min", int'(act_min), e_mn);
        chk("R5", "dev_hi", int'($signed(dev_hi)), e_hi);
        chk("R5", "dev_lo", int'($signed(dev_lo)), e_lo);
        chk("R6", "cnt_err", int'(cnt_err), e_err);
        p_fire = in_valid && rdy;
        p_reg = int'(in_region); p_dat = int'(in_data); p_last = in_last;
      end
    end
  end

  function automatic int pix(int pat, int i, int seed);
    case (pat)
      0: return (i * 23 + seed) % 256;
      1: return seed;
      2: return ((i * i * 37 + seed * 11) ^ (i << 3)) & 255;
      default: return (i % 2) ? 255 : 0;
    endcase
  endfunction

  task automatic step_lfsr();
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hb400 : 0);
  endtask

  task automatic drive(input int reg_c, input int dat, input bit last);
    step_lfsr();
    if (lfsr[2:0] == 3'd0) begin
      in_valid = 1'b0;
      @(posedge clk); #1;
    end
    in_valid = 1'b1; in_region = 2'(reg_c); in_data = DW'(dat); in_last = last;
    out_ready = lfsr[4:3] != 2'b00;
    forever begin
      @(negedge clk);
      if (in_ready) begin
        @(posedge clk); #1;
        break;
      end
      @(posedge clk); #1;
      out_ready = 1'b1;
    end
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  // R1: lead-in and guard slots carry hot values that must be excluded
  task automatic send_line(input int pat, input int n_act, input int seed);
    for (int i = 0; i < 4; i++) drive(0, 250, 0);
    for (int i = 0; i < N_OB; i++) drive(1, (seed + i * 5) % 64, 0);
    for (int i = 0; i < 2; i++) drive(3, 240, 0);
    for (int i = 0; i < n_act; i++) drive(2, pix(pat, i, seed), 0);
    drive(3, 245, 0);
    drive(3, 245, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "reset done", int'(done), 0);
    chk("R11", "reset ob_mean", int'(ob_mean), 0);
    chk("R11", "reset act_mean", int'(act_mean), 0);
    chk("R11", "reset cnt_err", int'(cnt_err), 0);
    chk("R11", "reset in_ready", int'(in_ready), 1);
    @(posedge clk); #1;
    send_line(0, N_ACT, 5);
    send_line(1, N_ACT, 77);
    send_line(2, N_ACT, 19);
    send_line(3, N_ACT, 0);
    send_line(1, N_ACT - 1, 200);
    send_line(1, N_ACT + 1, 180);
    send_line(2, N_ACT, 123);
    send_line(0, N_ACT, 250);
    repeat (LAT + 5) @(posedge clk);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++; mismatched++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule